// File: doc/BRIEF.md
# Local Write/Read Data Handshake Path

This block sits between a user port and a memory command engine. It accepts one burst command at a time: a valid strobe, a start address and a read/write flag. It passes the command to the memory side as a single-cycle request. It then runs the data phase of that burst and returns to idle.

For a write, the block asks for data with a request strobe, one cycle per beat. The user must place each beat on the write-data bus a fixed number of cycles after the matching request. That delay is one or two cycles and is chosen by a configuration input. The block captures each beat at that offset and forwards it to the memory side as a burst word.

For a read, the block takes burst words from the memory side and hands them to the user with a valid flag. It forwards exactly one burst length of words and ignores any surplus. The burst length is four or eight beats. Both the length and the write delay are sampled when the command is accepted.

Top module: `udp_data_path`

## Requirements
- R1: After reset, cmd_ready is 1 and wdata_req, rd_data_valid, mem_cmd_valid and mem_wr_valid are 0.
- R2: A command is taken in a cycle where cmd_valid and cmd_ready are both 1. From the next cycle, cmd_ready is 0 until the burst completes. cfg_bl8 and cfg_wdelay are sampled only at acceptance, so changing them during a burst has no effect on it.
- R3: In the cycle after acceptance, mem_cmd_valid is 1 for exactly one cycle, carrying the accepted address on mem_cmd_addr and the read/write flag on mem_cmd_write (1 = write).
- R4: The burst length is 4 beats when cfg_bl8 = 0 and 8 beats when cfg_bl8 = 1. For a write, wdata_req is 1 for exactly that many consecutive cycles, starting the cycle after acceptance.
- R5: Each write beat is taken from wr_data a fixed delay after its wdata_req cycle. The delay is 1 cycle when cfg_wdelay = 0 and 2 cycles when cfg_wdelay = 1. wr_data in any other cycle is ignored.
- R6: Each captured write beat appears on mem_wr_data with mem_wr_valid = 1 in the cycle after capture, with beats in request order.
- R7: During a read, each cycle with mem_rd_valid = 1 passes mem_rd_data to rd_data with rd_data_valid = 1 in the next cycle, in arrival order. Idle gaps between beats are allowed.
- R8: rd_data_valid is 1 for exactly the burst length of cycles per read. mem_rd_valid beats beyond that count, or with no read pending, never reach rd_data_valid.
- R9: cmd_ready returns to 1 in the cycle after the last write beat is captured or the last read beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| cfg_wdelay | input | 1 | Write data delay: 0 = 1 cycle, 1 = 2 cycles |
| cmd_valid | input | 1 | User command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_ready | output | 1 | Block idle, command can be taken |
| wdata_req | output | 1 | Request for one write beat |
| wr_data | input | DATA_W | User write data |
| rd_data | output | DATA_W | Read data to user |
| rd_data_valid | output | 1 | rd_data holds a valid beat |
| mem_cmd_valid | output | 1 | Command pulse to memory side |
| mem_cmd_write | output | 1 | Memory command direction |
| mem_cmd_addr | output | ADDR_W | Memory command address |
| mem_wr_data | output | DATA_W | Write beat to memory side |
| mem_wr_valid | output | 1 | mem_wr_data holds a valid beat |
| mem_rd_data | input | DATA_W | Read beat from memory side |
| mem_rd_valid | input | 1 | mem_rd_data holds a valid beat |

## Verification
The assertions check the cycle-level rules on every cycle: the single-cycle command pulse, cmd_ready low while a burst runs, the fixed distance from each request to its forwarded beat for the latched delay, and the cap on read-valid cycles per burst. They cannot show that the right word lands in the right beat. The bench scenarios cover this by driving junk outside the capture slots and comparing the forwarded words in order. The bench also changes the configuration in the middle of a burst and sends surplus read beats, then confirms that neither has any effect.

// File: rtl/udp_data_path.sv
module udp_data_path #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bl8,
  input  logic              cfg_wdelay,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              wdata_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              mem_cmd_valid,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_wr_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid
);
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} state_t;
  state_t st;

  logic             dly2;
  logic [CNT_W-1:0] blen, req_cnt, beat_cnt;
  logic [1:0]       req_sr;
  logic             accept, cap_en, rd_take, last_beat;

  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid & cmd_ready;
  assign wdata_req = (st == S_WR) && (req_cnt != blen);
  assign cap_en    = (st == S_WR) && (dly2 ? req_sr[1] : req_sr[0]);
  assign rd_take   = (st == S_RD) && mem_rd_valid;
  assign last_beat = (beat_cnt == blen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      dly2          <= 1'b0;
      blen          <= CNT_W'(4);
      req_cnt       <= '0;
      beat_cnt      <= '0;
      req_sr        <= '0;
      mem_cmd_valid <= 1'b0;
      mem_cmd_write <= 1'b0;
      mem_cmd_addr  <= '0;
      mem_wr_valid  <= 1'b0;
      mem_wr_data   <= '0;
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      req_sr        <= {req_sr[0], wdata_req};
      mem_cmd_valid <= accept;
      mem_wr_valid  <= cap_en;
      rd_data_valid <= rd_take;
      if (cap_en)  mem_wr_data <= wr_data;
      if (rd_take) rd_data     <= mem_rd_data;
      if (wdata_req) req_cnt <= req_cnt + 1'b1;

      if (accept) begin
        st            <= cmd_write ? S_WR : S_RD;
        dly2          <= cfg_wdelay;
        blen          <= cfg_bl8 ? CNT_W'(8) : CNT_W'(4);
        req_cnt       <= '0;
        beat_cnt      <= '0;
        mem_cmd_write <= cmd_write;
        mem_cmd_addr  <= cmd_addr;
      end else if (cap_en || rd_take) begin
        beat_cnt <= beat_cnt + 1'b1;
        if (last_beat) st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/udp_data_path_chk.sv
module udp_data_path_chk #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_bl8,
  input logic              cfg_wdelay,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ready,
  input logic              wdata_req,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_data_valid,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_write,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_valid,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic              mem_rd_valid
);
  logic       c_dly2;
  logic [3:0] c_bl, c_rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_dly2 <= 1'b0; c_bl <= 4'd4; c_rd_seen <= '0;
    end else if (cmd_valid && cmd_ready) begin
      c_dly2 <= cfg_wdelay; c_bl <= cfg_bl8 ? 4'd8 : 4'd4; c_rd_seen <= '0;
    end else if (rd_data_valid) begin
      c_rd_seen <= c_rd_seen + 1'b1;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (mem_cmd_valid && mem_cmd_addr == $past(cmd_addr)));
  p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |=> !mem_cmd_valid);
  p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_req |-> !cmd_ready);
  p_wdelay1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_req && !c_dly2) |=> ##1 mem_wr_valid);
  p_wdelay2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_req && c_dly2) |=> ##2 mem_wr_valid);
  p_rd_from_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> $past(mem_rd_valid));
  p_rd_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> (c_rd_seen < c_bl));
endmodule

bind udp_data_path udp_data_path_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_udp_data_path.sv
module tb_udp_data_path;
  localparam int AW = 28, DW = 64;
  logic clk = 0, rst_n = 0;
  logic cfg_bl8 = 0, cfg_wdelay = 0, cmd_valid = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_ready, wdata_req, rd_data_valid, mem_cmd_valid, mem_cmd_write, mem_wr_valid;
  logic [DW-1:0] wr_data = '0, rd_data, mem_wr_data, mem_rd_data = '0;
  logic [AW-1:0] mem_cmd_addr;
  logic mem_rd_valid = 0;
  int tests = 0, fails = 0, cyc = 0;

  udp_data_path #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic issue(input bit wr, input bit bl8, input bit d2, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cfg_bl8 = bl8; cfg_wdelay = d2;
    @(negedge clk);
    cmd_valid = 0; cfg_bl8 = ~bl8; cfg_wdelay = ~d2;
    check(cmd_ready == 0, "R2 busy after accept", cmd_ready, 0);
    check(mem_cmd_valid && mem_cmd_write == wr && mem_cmd_addr == a, "R3 command pulse",
          mem_cmd_addr, a);
  endtask

  task automatic run_write(input bit bl8, input bit d2, input logic [AW-1:0] a);
    logic [DW-1:0] exp_w[8], got[8];
    int sched[40];
    int bl = bl8 ? 8 : 4, d = d2 ? 2 : 1, reqs = 0, n = 0;
    bit req_ok = 1, rdy_ok = 1, ord_ok = 1, pulse_ok = 1;
    foreach (exp_w[i]) exp_w[i] = rnd64();
    foreach (sched[i]) sched[i] = -1;
    issue(1, bl8, d2, a);
    for (int t = 0; t < 24; t++) begin
      if (t > 0 && mem_cmd_valid) pulse_ok = 0;
      if (wdata_req !== (t < bl)) req_ok = 0;
      if (cmd_ready !== (t >= bl + d)) rdy_ok = 0;
      if (wdata_req) begin sched[t + d] = reqs; reqs++; end
      if (mem_wr_valid) begin
        if (n < 8) got[n] = mem_wr_data;
        n++;
      end
      wr_data = (sched[t] >= 0) ? exp_w[sched[t]] : rnd64();
      @(negedge clk);
    end
    for (int i = 0; i < bl && i < n; i++) if (got[i] != exp_w[i]) ord_ok = 0;
    check(pulse_ok, "R3 single-cycle command pulse", 0, 0);
    check(req_ok && reqs == bl, "R4 request strobe count", reqs, bl);
    check(n == bl, "R6 forwarded write beats", n, bl);
    check(ord_ok, d2 ? "R5 two-cycle capture order" : "R5 one-cycle capture order", got[0], exp_w[0]);
    check(rdy_ok, "R9 ready after last capture", cmd_ready, 1);
  endtask

  task automatic run_read(input bit bl8, input logic [AW-1:0] a, input bit extra);
    logic [DW-1:0] exp_w[8], got[8];
    int bl = bl8 ? 8 : 4, k = 0, n = 0, last_t = 1000;
    bit ord_ok = 1, rdy_ok = 1;
    foreach (exp_w[i]) exp_w[i] = rnd64();
    issue(0, bl8, 0, a);
    for (int t = 0; t < 70; t++) begin
      if (rd_data_valid) begin
        if (n < 8) got[n] = rd_data;
        n++;
      end
      if (cmd_ready !== (t > last_t)) rdy_ok = 0;
      if ($urandom % 3 != 0 && (k < bl || extra)) begin
        mem_rd_valid = 1;
        mem_rd_data = (k < bl) ? exp_w[k] : rnd64();
        if (k == bl - 1) last_t = t;
        k++;
      end else begin
        mem_rd_valid = 0; mem_rd_data = rnd64();
      end
      @(negedge clk);
    end
    mem_rd_valid = 0;
    for (int i = 0; i < bl && i < n; i++) if (got[i] != exp_w[i]) ord_ok = 0;
    check(ord_ok, "R7 read data order", got[0], exp_w[0]);
    check(n == bl, extra ? "R8 surplus beats dropped" : "R8 read valid count", n, bl);
    check(rdy_ok, "R9 ready after last read beat", cmd_ready, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready && !wdata_req && !rd_data_valid && !mem_cmd_valid && !mem_wr_valid,
          "R1 reset state", {cmd_ready, wdata_req, rd_data_valid, mem_cmd_valid, mem_wr_valid}, 5'b10000);
    // stray read beats with nothing pending (R8)
    mem_rd_valid = 1; mem_rd_data = rnd64();
    @(negedge clk);
    @(negedge clk);
    check(!rd_data_valid, "R8 beat with no read pending", rd_data_valid, 0);
    mem_rd_valid = 0;
    run_write(0, 0, 28'h0000100);
    run_write(1, 0, 28'h0000200);
    run_write(0, 1, 28'h0000300);
    run_write(1, 1, 28'hfffff00);
    run_read(0, 28'h0000100, 0);
    run_read(1, 28'h0000200, 0);
    run_read(1, 28'h0000400, 1);
    run_read(0, 28'h0000500, 1);
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2) run_write($urandom % 2, $urandom % 2, AW'($urandom));
      else run_read($urandom % 2, AW'($urandom), $urandom % 2);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule